// File: doc/BRIEF.md
# Iterative Unsigned Multiply-Divide Unit

This block performs one of two unsigned 16-bit operations on three fixed accumulator values. A multiply computes `ac1 × ac2 + ac0` as a 32-bit number. It returns the upper half in the first result word and the lower half in the second. A divide treats `ac0:ac1` as a 32-bit dividend, with `ac0` as the high word, and divides it by `ac2`. It returns the remainder in the first result word and the quotient in the second. Neither operation gives the sign bit any special meaning.

A caller presents the operands and raises `start` while the unit is idle. The operands are captured on that clock edge. The unit then processes one bit per clock: shift-and-add for a multiply, and restoring shift-and-subtract for a divide. `busy` stays high for the whole run, and a single-cycle `done` marks the cycle in which the results are valid. The results are held until the next accepted operation.

A divide whose quotient would not fit in 16 bits is detected before any iteration. Division by zero is one such case. The unit raises the carry flag, returns the original accumulator values and finishes at once.

Top module: `muldiv_unit`

## Requirements
- R1: With `op_div`=0, the unit returns `ac0_out` = bits 31..16 and `ac1_out` = bits 15..0 of the unsigned value `ac1_in*ac2_in + ac0_in`.
- R2: With `op_div`=1 and `ac0_in` < `ac2_in`, the unit returns `ac1_out` = the unsigned quotient and `ac0_out` = the remainder of `{ac0_in,ac1_in}` / `ac2_in`.
- R3: With `op_div`=1 and `ac0_in` >= `ac2_in` (this includes `ac2_in`=0), the unit returns `carry_out`=1 and `ac0_out`/`ac1_out` equal to `ac0_in`/`ac1_in`. `done` rises on the edge that accepts `start`, and `busy` never rises.
- R4: A divide that completes without overflow returns `carry_out`=0.
- R5: A multiply returns `carry_out` equal to the `carry_in` value captured at start.
- R6: A non-overflowing operation shows `done` after exactly 16 clock edges following the edge that accepted `start`.
- R7: While `busy` is high, `start` is ignored: the operands and the operation in progress are unaffected.
- R8: `busy` is high from acceptance until the operation ends. `done` is never high together with `busy`, and each operation yields exactly one single-cycle `done`.
- R9: After a synchronous active-low reset, `busy`, `done`, `ac0_out`, `ac1_out` and `carry_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Requests an operation; accepted only while idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| ac0_in | input | 16 | Addend (multiply) or dividend high word (divide) |
| ac1_in | input | 16 | Multiplier (multiply) or dividend low word (divide) |
| ac2_in | input | 16 | Multiplicand (multiply) or divisor (divide) |
| carry_in | input | 1 | Carry value passed through by a multiply |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; results valid |
| ac0_out | output | 16 | Product high word or remainder |
| ac1_out | output | 16 | Product low word or quotient |
| carry_out | output | 1 | Divide overflow flag, or the captured carry after a multiply |

## Verification
The in-line properties watch the following on every cycle:
- `busy` and `done` never overlap, and the end of `busy` always coincides with `done`.
- The captured divisor and the carry stay frozen during a run, even while `start` is held high.
- After each divide step the partial remainder stays below the divisor.
- An overflowing divide finishes on the next edge with its inputs returned unchanged.

Only the bench's scenarios can show the arithmetic values themselves: the product plus addend at the extremes, and quotient/remainder pairs. They also show the exact 16-edge latency, the carry pass-through on a multiply, and the reset values.

// File: rtl/muldiv_pkg.sv
// Package: shared operation encoding for the multiply-divide unit.
// Assumes: 1-bit operation select, 0 = multiply, 1 = divide.
package muldiv_pkg;
    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;
endpackage

// File: rtl/muldiv_ctrl.sv
// Module: muldiv_ctrl
// Sequences one operation. It accepts start only when idle, counts WIDTH
// iteration cycles and produces a single done pulse. An overflowing divide
// (ovf) skips the iterations and finishes on the accepting edge.
// Assumes: ovf is valid in the same cycle as start.
module muldiv_ctrl #(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ovf,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;

    // Accept a new operation only while idle.
    always_comb load = start && !busy_q;

    always_comb step = busy_q;
    always_comb busy = busy_q;
    always_comb done = done_q;

    // Iteration counter, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= (load && ovf) || (busy_q && cnt_q == LAST);
            if (load) begin
                busy_q <= !ovf;
                cnt_q  <= '0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // R8: busy and done never overlap
    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && done_q));

    // R8: the end of a run always comes with done
    assert_fell_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);

    // R3: an overflowing divide finishes at once without going busy
    assert_ovf_quick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ovf) |=> (done_q && !busy_q));
endmodule

// File: rtl/muldiv_dp.sv
// Module: muldiv_dp
// Datapath: captures the operands on load, then performs one shift-add
// (multiply) or restoring shift-subtract (divide) step per enabled cycle.
// hi holds the addend/partial product or the partial remainder; lo holds
// the multiplier/low product bits or the dividend/quotient bits.
// Assumes: step is never high together with load.
module muldiv_dp
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  md_op_e           op_in,
    input  logic [WIDTH-1:0] a0,
    input  logic [WIDTH-1:0] a1,
    input  logic [WIDTH-1:0] a2,
    input  logic             cin,
    output logic             ovf,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo,
    output logic             cout
);
    md_op_e           op_q;
    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] lo_q;
    logic             cout_q;

    logic [WIDTH:0]   sum;
    logic [WIDTH:0]   sh;
    logic             ge;
    logic [WIDTH-1:0] diff;

    // The quotient does not fit when the high dividend word reaches the divisor.
    always_comb ovf = (op_in == OP_DIV) && (a0 >= a2);

    // One multiply step: conditionally add the multiplicand to the upper half.
    always_comb sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);

    // One divide step: shift the remainder left and trial-subtract the divisor.
    always_comb begin
        sh   = {hi_q, lo_q[WIDTH-1]};
        ge   = sh >= {1'b0, mcand_q};
        diff = sh[WIDTH-1:0] - mcand_q;
    end

    // Operand capture and the iteration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_MUL;
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            cout_q  <= 1'b0;
        end else if (load) begin
            op_q    <= op_in;
            mcand_q <= a2;
            hi_q    <= a0;
            lo_q    <= a1;
            cout_q  <= ovf ? 1'b1 : ((op_in == OP_DIV) ? 1'b0 : cin);
        end else if (step) begin
            if (op_q == OP_MUL) begin
                hi_q <= sum[WIDTH:1];
                lo_q <= {sum[0], lo_q[WIDTH-1:1]};
            end else begin
                hi_q <= ge ? diff : sh[WIDTH-1:0];
                lo_q <= {lo_q[WIDTH-2:0], ge};
            end
        end
    end

    always_comb begin
        hi   = hi_q;
        lo   = lo_q;
        cout = cout_q;
    end

    // R7: the captured divisor/multiplicand cannot change during a run
    assert_mcand_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(mcand_q));

    // R5: the carry is frozen while iterating
    assert_carry_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(cout_q));

    // R2: the partial remainder stays below the divisor after every step
    assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op_q == OP_DIV) |=> (hi_q < mcand_q));

    // R3: an overflowing divide returns its inputs with the carry set
    assert_ovf_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ovf) |=> (hi_q == $past(a0) && lo_q == $past(a1) && cout_q));
endmodule

// File: rtl/muldiv_unit.sv
// Module: muldiv_unit (top)
// Unsigned iterative multiply-add / divide over fixed accumulators.
// Takes one cycle to accept and WIDTH cycles per operation. An overflowing
// divide completes on the accepting edge.
// Assumes: the operands are valid in the cycle start is raised.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_div,
    input  logic [WIDTH-1:0] ac0_in,
    input  logic [WIDTH-1:0] ac1_in,
    input  logic [WIDTH-1:0] ac2_in,
    input  logic             carry_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] ac0_out,
    output logic [WIDTH-1:0] ac1_out,
    output logic             carry_out
);
    logic   load;
    logic   step;
    logic   ovf;
    md_op_e op_sel;

    // Map the raw select bit onto the operation type.
    always_comb op_sel = md_op_e'(op_div);

    muldiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ovf   (ovf),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    muldiv_dp #(.WIDTH(WIDTH)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .op_in (op_sel),
        .a0    (ac0_in),
        .a1    (ac1_in),
        .a2    (ac2_in),
        .cin   (carry_in),
        .ovf   (ovf),
        .hi    (ac0_out),
        .lo    (ac1_out),
        .cout  (carry_out)
    );
endmodule

// File: tb/tb_muldiv_unit.sv
// Scoreboard bench: the driver pushes the expected result and the completion
// cycle, and the monitor pops and compares them on each done pulse.
module tb_muldiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic [15:0] ac0_in = '0, ac1_in = '0, ac2_in = '0;
    logic        carry_in = 1'b0;
    logic        busy, done, carry_out;
    logic [15:0] ac0_out, ac1_out;

    typedef struct {
        logic [15:0] e0;
        logic [15:0] e1;
        logic        ec;
        int          ecyc;
        string       req;
    } exp_t;

    exp_t  sb[$];
    int    cyc = 0;
    int    n_tests = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    muldiv_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .ac0_in(ac0_in), .ac1_in(ac1_in), .ac2_in(ac2_in), .carry_in(carry_in),
        .busy(busy), .done(done), .ac0_out(ac0_out), .ac1_out(ac1_out),
        .carry_out(carry_out)
    );

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: called at a negedge; waits for idle, then issues one operation.
    task automatic issue(input logic op, input logic [15:0] a0, input logic [15:0] a1,
                         input logic [15:0] a2, input logic c, input string req);
        exp_t        it;
        logic [31:0] p;
        int          lat;
        while (busy) @(negedge clk);
        if (!op) begin
            p     = {16'b0, a1} * {16'b0, a2} + {16'b0, a0};
            it.e0 = p[31:16];
            it.e1 = p[15:0];
            it.ec = c;
            lat   = 16;
        end else if (a0 >= a2) begin
            it.e0 = a0;
            it.e1 = a1;
            it.ec = 1'b1;
            lat   = 0;
        end else begin
            p     = {a0, a1};
            it.e1 = 16'(p / {16'b0, a2});
            it.e0 = 16'(p % {16'b0, a2});
            it.ec = 1'b0;
            lat   = 16;
        end
        it.ecyc = cyc + 1 + lat;
        it.req  = req;
        sb.push_back(it);
        op_div = op; ac0_in = a0; ac1_in = a1; ac2_in = a2; carry_in = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: compares every done pulse against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy && done) check("R8", "busy with done", 32'd1, 32'd0);
            if (done) begin
                if (sb.size() == 0) begin
                    check("R8", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    check(it.req, "ac0_out", {16'b0, ac0_out}, {16'b0, it.e0});
                    check(it.req, "ac1_out", {16'b0, ac1_out}, {16'b0, it.e1});
                    check(it.req, "carry_out", {31'b0, carry_out}, {31'b0, it.ec});
                    check("R6", "done cycle", 32'(cyc), 32'(it.ecyc));
                end
            end
        end
    end

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R6 watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "busy", {31'b0, busy}, 32'd0);
        check("R9", "done", {31'b0, done}, 32'd0);
        check("R9", "ac0_out", {16'b0, ac0_out}, 32'd0);
        check("R9", "ac1_out", {16'b0, ac1_out}, 32'd0);
        check("R9", "carry_out", {31'b0, carry_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R5: multiply-add, carry passes through
        issue(1'b0, 16'd0, 16'd3, 16'd5, 1'b0, "R1");
        issue(1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, "R5");
        issue(1'b0, 16'h1234, 16'h8000, 16'h0002, 1'b0, "R1");
        issue(1'b0, 16'h0007, 16'h0000, 16'hABCD, 1'b1, "R5");
        // R2 / R4: divide
        issue(1'b1, 16'h0001, 16'h0000, 16'h0003, 1'b1, "R2");
        issue(1'b1, 16'h0000, 16'd100, 16'd7, 1'b1, "R4");
        issue(1'b1, 16'hFFFE, 16'hFFFF, 16'hFFFF, 1'b0, "R2");
        issue(1'b1, 16'h0000, 16'h0005, 16'h0009, 1'b1, "R2");
        // R3: overflow, equal case and divide by zero, back to back
        issue(1'b1, 16'h0005, 16'h1111, 16'h0005, 1'b0, "R3");
        issue(1'b1, 16'h0000, 16'h2222, 16'h0000, 1'b0, "R3");
        issue(1'b1, 16'hFFFF, 16'h0001, 16'h0010, 1'b0, "R3");
        drain();
        check("R3", "busy after overflow", {31'b0, busy}, 32'd0);

        // R7: start held during a run with other operands is ignored
        issue(1'b0, 16'h0011, 16'h0100, 16'h0020, 1'b0, "R7");
        for (int i = 0; i < 5; i++) begin
            op_div = 1'b1; ac0_in = 16'h0000; ac1_in = 16'(i * 9 + 1);
            ac2_in = 16'h0003; carry_in = 1'b1; start = 1'b1;
            check("R8", "busy during run", {31'b0, busy}, 32'd1);
            @(negedge clk);
        end
        start = 1'b0;
        drain();

        // Mixed patterns
        lcg = 32'h1ACE_5EED;
        for (int i = 0; i < 24; i++) begin
            logic [15:0] x0, x1, x2;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            x0  = lcg[31:16];
            lcg = lcg * 32'd1103515245 + 32'd12345;
            x1  = lcg[31:16];
            lcg = lcg * 32'd1103515245 + 32'd12345;
            x2  = lcg[31:16] | 16'h0001;
            if (i % 2 == 0) issue(1'b0, x0, x1, x2, lcg[3], "R1");
            else issue(1'b1, (i % 6 == 1) ? x0 : 16'(x0 % x2), x1, x2, lcg[3], "R2");
        end
        drain();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule